// File: doc/BRIEF.md
# TLP Beat Packer for a 64-bit Transmit Stream

This block turns one transaction layer packet at a time into beats of a 64-bit transmit stream. It loads a header of three or four dwords in one register write. The header is given as sixteen bytes in wire order. The payload arrives one dword per cycle on a valid/ready input. The block places these dwords into the low lane (bits 31:0) and high lane (bits 63:32) of each output beat. It marks the first beat with start-of-packet and the last beat with end-of-packet.

Header dwords are emitted big-endian: the earliest header byte is in the top byte of its dword. Payload dwords pass through unchanged, with the earliest data byte in the bottom byte. Address bit 2 states where the first payload dword must sit. A clear bit means qword aligned, so the first payload dword goes in the low lane. A set bit means it goes in the high lane. When the lane that follows the header is the wrong one, the block leaves that lane idle (zero) before the payload starts. The output holds every field while the sink stalls. A new header is taken only after the previous end-of-packet beat has left.

Top module: `tlp_beat_packer`

## Requirements
- R1: The first beat of a packet carries header dword 0 in bits 31:0 and header dword 1 in bits 63:32, and has out_sop=1. No other beat has out_sop=1.
- R2: Header dword k is {byte 4k, byte 4k+1, byte 4k+2, byte 4k+3}, with byte 4k in bits 31:24. Header byte i is input bits hdr_bytes[8i+7:8i].
- R3: With hdr_four=1, the second beat carries header dword 2 in the low lane and header dword 3 in the high lane.
- R4: A payload dword appears in its lane exactly as presented on pay_data. Data byte 4N+j of dword N stays in bits 8j+7:8j.
- R5: With hdr_four=1 and addr_bit2=0, the payload starts on the beat after the header. Dword 0 is in the low lane, dword 1 in the high lane, and later dwords pair up the same way.
- R6: With hdr_four=1 and addr_bit2=1, the first payload beat has a zero low lane and payload dword 0 in the high lane. Dwords 1 and 2 fill the next beat's low and high lanes, and so on.
- R7: With hdr_four=0, header dword 2 takes the low lane of the second beat. If addr_bit2=1, payload dword 0 takes that beat's high lane. If addr_bit2=0 and the payload is not empty, that high lane is zero and the payload starts in the low lane of the next beat.
- R8: out_eop=1 is set on exactly one beat per packet. That beat carries the last payload dword, or the last header dword when pay_len=0.
- R9: When the final beat fills only its low lane, bits 63:32 are zero and out_hi_empty=1. On every other beat out_hi_empty=0.
- R10: While out_valid=1 and out_ready=0, out_valid, out_data, out_sop, out_eop and out_hi_empty stay unchanged into the next cycle.
- R11: hdr_ready is 0 from the cycle after a header is accepted until the packet's end-of-packet beat has been transferred. A hdr_load pulse while hdr_ready=0 has no effect.
- R12: pay_ready is 1 only while the current packet is waiting for a payload dword. With no packet in progress, pay_ready is 0 and pay_valid is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_load | input | 1 | Load the header fields; taken when hdr_ready=1 |
| hdr_bytes | input | 128 | Header bytes, byte i in bits 8i+7:8i |
| hdr_four | input | 1 | 1: four-dword header, 0: three-dword header |
| addr_bit2 | input | 1 | Address bit 2 of the payload (1 = not qword aligned) |
| pay_len | input | LEN_W | Payload length in dwords, may be zero |
| hdr_ready | output | 1 | Ready for a new header |
| pay_valid | input | 1 | Payload dword present |
| pay_data | input | 32 | Payload dword |
| pay_ready | output | 1 | Payload dword taken when pay_valid=1 |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink accepts the beat |
| out_data | output | 64 | Beat: low lane 31:0, high lane 63:32 |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_hi_empty | output | 1 | Upper lane of this final beat is unused |

## Verification
The checker watches several rules on every cycle. It checks that a stalled beat holds all of its fields, and that an empty upper lane is zero and comes only on an end-of-packet beat. It also checks that a start beat is always full, and that neither header nor payload readiness is raised while the wrong phase is in progress. Lane placement, the choice of idle lane, byte order and the position of end-of-packet depend on the header size, address bit 2 and payload length. Only the bench's sweep over those three settings, under steady and irregular sink readiness, can show them.

// File: rtl/tlpfmt_pkg.sv
package tlpfmt_pkg;

    localparam int LANE_W    = 32;
    localparam int BEAT_W    = 2 * LANE_W;
    localparam int HDR_BYTES = 16;
    localparam int HDR_W     = 8 * HDR_BYTES;

    typedef enum logic [1:0] {
        SLOT_HDR = 2'd0,
        SLOT_GAP = 2'd1,
        SLOT_PAY = 2'd2
    } slot_kind_e;

    typedef struct packed {
        logic [LANE_W-1:0] hi;
        logic [LANE_W-1:0] lo;
    } beat_t;

    typedef struct packed {
        logic sop;
        logic eop;
        logic hi_empty;
    } beat_marks_t;

    // Header dword k, earliest byte in the most significant position.
    function automatic logic [LANE_W-1:0] hdr_dword(input logic [HDR_W-1:0] bytes,
                                                     input logic [1:0] k);
        logic [LANE_W-1:0] r;
        r = '0;
        for (int j = 0; j < 4; j++) begin
            r[LANE_W-1-8*j -: 8] = bytes[32*k + 8*j +: 8];
        end
        return r;
    endfunction

    // An idle lane is needed when the lane after the header disagrees with address bit 2.
    function automatic logic gap_needed(input logic hdr4, input logic addr2, input logic has_pay);
        return has_pay && (hdr4 == addr2);
    endfunction

endpackage

// File: rtl/tlpfmt_hdr_store.sv
module tlpfmt_hdr_store
    import tlpfmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [HDR_W-1:0]     bytes_in,
    input  logic [1:0]           idx,
    output logic [LANE_W-1:0]    dword_out
);

    logic [HDR_W-1:0] hdr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q <= '0;
        end else if (load) begin
            hdr_q <= bytes_in;
        end
    end

    assign dword_out = hdr_dword(hdr_q, idx);

endmodule

// File: rtl/tlpfmt_slot_seq.sv
module tlpfmt_slot_seq
    import tlpfmt_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             hdr4_in,
    input  logic             addr2_in,
    input  logic [LEN_W-1:0] len_in,
    input  logic             advance,
    output logic             busy,
    output slot_kind_e       kind,
    output logic [1:0]       hdr_idx,
    output logic             hi_slot,
    output logic             last_slot,
    output logic             first_beat
);

    localparam int SW = LEN_W + 3;

    logic          busy_q;
    logic          hdr4_q;
    logic          gap_q;
    logic [SW-1:0] slot_q;
    logic [SW-1:0] last_q;
    logic [SW-1:0] hdr_cnt;
    logic          gap_start;

    assign gap_start = gap_needed(hdr4_in, addr2_in, len_in != '0);
    assign hdr_cnt   = hdr4_q ? SW'(4) : SW'(3);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            hdr4_q <= 1'b0;
            gap_q  <= 1'b0;
            slot_q <= '0;
            last_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            hdr4_q <= hdr4_in;
            gap_q  <= gap_start;
            slot_q <= '0;
            last_q <= (hdr4_in ? SW'(4) : SW'(3)) + SW'(gap_start) + SW'(len_in) - SW'(1);
        end else if (advance) begin
            if (slot_q == last_q) begin
                busy_q <= 1'b0;
            end else begin
                slot_q <= slot_q + SW'(1);
            end
        end
    end

    always_comb begin
        if (slot_q < hdr_cnt) begin
            kind = SLOT_HDR;
        end else if (gap_q && (slot_q == hdr_cnt)) begin
            kind = SLOT_GAP;
        end else begin
            kind = SLOT_PAY;
        end
    end

    assign busy       = busy_q;
    assign hdr_idx    = slot_q[1:0];
    assign hi_slot    = slot_q[0];
    assign last_slot  = (slot_q == last_q);
    assign first_beat = (slot_q[SW-1:1] == '0);

endmodule

// File: rtl/tlpfmt_beat_asm.sv
module tlpfmt_beat_asm
    import tlpfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              hi_slot,
    input  logic              completes,
    input  logic [LANE_W-1:0] lane_val,
    input  logic              sop_in,
    input  logic              eop_in,
    input  logic              out_ready,
    output logic              out_free,
    output logic              out_valid,
    output beat_t             out_beat,
    output beat_marks_t       out_marks
);

    logic [LANE_W-1:0] lo_q;
    logic              valid_q;
    beat_t             beat_q;
    beat_marks_t       marks_q;

    assign out_free = !valid_q || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q    <= '0;
            valid_q <= 1'b0;
            beat_q  <= '0;
            marks_q <= '0;
        end else begin
            if (valid_q && out_ready) begin
                valid_q <= 1'b0;
            end
            if (take) begin
                if (!hi_slot) begin
                    lo_q <= lane_val;
                end
                if (completes) begin
                    valid_q          <= 1'b1;
                    beat_q.lo        <= hi_slot ? lo_q : lane_val;
                    beat_q.hi        <= hi_slot ? lane_val : '0;
                    marks_q.sop      <= sop_in;
                    marks_q.eop      <= eop_in;
                    marks_q.hi_empty <= !hi_slot;
                end
            end
        end
    end

    assign out_valid = valid_q;
    assign out_beat  = beat_q;
    assign out_marks = marks_q;

endmodule

// File: rtl/tlp_beat_packer.sv
module tlp_beat_packer
    import tlpfmt_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hdr_load,
    input  logic [127:0]     hdr_bytes,
    input  logic             hdr_four,
    input  logic             addr_bit2,
    input  logic [LEN_W-1:0] pay_len,
    output logic             hdr_ready,
    input  logic             pay_valid,
    input  logic [31:0]      pay_data,
    output logic             pay_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [63:0]      out_data,
    output logic             out_sop,
    output logic             out_eop,
    output logic             out_hi_empty
);

    logic              busy;
    slot_kind_e        kind;
    logic [1:0]        hdr_idx;
    logic              hi_slot;
    logic              last_slot;
    logic              first_beat;
    logic              hdr_acc;
    logic              completes;
    logic              slot_ok;
    logic              room;
    logic              advance;
    logic              out_free;
    logic [LANE_W-1:0] hdr_word;
    logic [LANE_W-1:0] lane_val;
    beat_t             beat;
    beat_marks_t       marks;

    assign hdr_ready = !busy && !out_valid;
    assign hdr_acc   = hdr_load && hdr_ready;
    assign completes = hi_slot || last_slot;
    assign slot_ok   = busy && ((kind != SLOT_PAY) || pay_valid);
    assign room      = !completes || out_free;
    assign advance   = slot_ok && room;
    assign pay_ready = busy && (kind == SLOT_PAY) && room;

    always_comb begin
        unique case (kind)
            SLOT_HDR: lane_val = hdr_word;
            SLOT_PAY: lane_val = pay_data;
            default:  lane_val = '0;
        endcase
    end

    tlpfmt_hdr_store i_hdr (
        .clk       (clk),
        .rst       (rst),
        .load      (hdr_acc),
        .bytes_in  (hdr_bytes),
        .idx       (hdr_idx),
        .dword_out (hdr_word)
    );

    tlpfmt_slot_seq #(.LEN_W(LEN_W)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (hdr_acc),
        .hdr4_in    (hdr_four),
        .addr2_in   (addr_bit2),
        .len_in     (pay_len),
        .advance    (advance),
        .busy       (busy),
        .kind       (kind),
        .hdr_idx    (hdr_idx),
        .hi_slot    (hi_slot),
        .last_slot  (last_slot),
        .first_beat (first_beat)
    );

    tlpfmt_beat_asm i_asm (
        .clk       (clk),
        .rst       (rst),
        .take      (advance),
        .hi_slot   (hi_slot),
        .completes (completes),
        .lane_val  (lane_val),
        .sop_in    (first_beat),
        .eop_in    (last_slot),
        .out_ready (out_ready),
        .out_free  (out_free),
        .out_valid (out_valid),
        .out_beat  (beat),
        .out_marks (marks)
    );

    assign out_data     = beat;
    assign out_sop      = marks.sop;
    assign out_eop      = marks.eop;
    assign out_hi_empty = marks.hi_empty;

endmodule

// File: rtl/tlpfmt_checker.sv
module tlpfmt_checker (
    input logic        clk,
    input logic        rst,
    input logic        hdr_ready,
    input logic        pay_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [63:0] out_data,
    input logic        out_sop,
    input logic        out_eop,
    input logic        out_hi_empty
);

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop)
                                       && $stable(out_eop) && $stable(out_hi_empty)));

    assert_hi_empty_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_hi_empty) |-> (out_data[63:32] == 32'h0 && out_eop));

    assert_sop_full_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop) |-> !out_hi_empty);

    assert_no_hdr_while_out_R11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !hdr_ready);

    assert_no_pay_when_idle_R12: assert property (@(posedge clk) disable iff (rst)
        hdr_ready |-> !pay_ready);

endmodule

bind tlp_beat_packer tlpfmt_checker i_chk (
    .clk          (clk),
    .rst          (rst),
    .hdr_ready    (hdr_ready),
    .pay_ready    (pay_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_sop      (out_sop),
    .out_eop      (out_eop),
    .out_hi_empty (out_hi_empty)
);

// File: tb/test_tlp_beat_packer.sv
module test_tlp_beat_packer;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 10;
    localparam int NCFG       = 28;
    localparam int NPK        = 2 * NCFG;
    localparam int WD_CYCLES  = 20000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             hdr_load = 1'b0;
    logic [127:0]     hdr_bytes = '0;
    logic             hdr_four = 1'b0;
    logic             addr_bit2 = 1'b0;
    logic [LEN_W-1:0] pay_len = '0;
    logic             hdr_ready;
    logic             pay_valid = 1'b0;
    logic [31:0]      pay_data = '0;
    logic             pay_ready;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [63:0]      out_data;
    logic             out_sop;
    logic             out_eop;
    logic             out_hi_empty;

    int n_chk  = 0;
    int n_fail = 0;
    int pk_mon = 0;
    int bt     = 0;
    int cyc    = 0;
    bit mon_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlp_beat_packer #(.LEN_W(LEN_W)) i_tlp_beat_packer (
        .clk(clk), .rst(rst), .hdr_load(hdr_load), .hdr_bytes(hdr_bytes),
        .hdr_four(hdr_four), .addr_bit2(addr_bit2), .pay_len(pay_len),
        .hdr_ready(hdr_ready), .pay_valid(pay_valid), .pay_data(pay_data),
        .pay_ready(pay_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .out_hi_empty(out_hi_empty)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Packet settings derived from the packet number.
    function automatic bit cfg_h4(int p); return (p % NCFG) % 2 == 1; endfunction
    function automatic bit cfg_a2(int p); return ((p % NCFG) / 2) % 2 == 1; endfunction
    function automatic int cfg_n(int p);  return (p % NCFG) / 4; endfunction

    function automatic logic [7:0] hbyte(int p, int i); return 8'((p * 16 + i) & 255); endfunction

    function automatic logic [31:0] pword(int p, int i);
        return {8'(p), 8'(i), 8'(p ^ 8'h5A), 8'(i + 8'h11)};
    endfunction

    function automatic int hcnt(int p); return cfg_h4(p) ? 4 : 3; endfunction
    function automatic int gcnt(int p);
        return (cfg_n(p) > 0 && (cfg_h4(p) == cfg_a2(p))) ? 1 : 0;
    endfunction
    function automatic int tslots(int p); return hcnt(p) + gcnt(p) + cfg_n(p); endfunction

    function automatic logic [31:0] exp_lane(int p, int k);
        int h = hcnt(p);
        int g = gcnt(p);
        if (k < h) return {hbyte(p, 4*k), hbyte(p, 4*k+1), hbyte(p, 4*k+2), hbyte(p, 4*k+3)};
        if (g == 1 && k == h) return 32'h0;
        if (k - h - g < cfg_n(p)) return pword(p, k - h - g);
        return 32'h0;
    endfunction

    // Output monitor: drives out_ready at the falling edge and checks beats that will transfer.
    logic [63:0] st_data;
    logic [2:0]  st_marks;
    bit          st_prev = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            out_ready = (pk_mon < NCFG) ? 1'b1 : ((cyc % 3) != 1);
            if (st_prev) begin
                chk(out_valid && out_data == st_data && {out_sop, out_eop, out_hi_empty} == st_marks,
                    "R10 stalled beat held", out_data, st_data);
            end
            st_prev  = out_valid && !out_ready;
            st_data  = out_data;
            st_marks = {out_sop, out_eop, out_hi_empty};
            if (out_valid && out_ready && pk_mon < NPK) begin
                automatic int p  = pk_mon;
                automatic int t  = tslots(p);
                automatic int nb = (t + 1) / 2;
                automatic logic [63:0] e = {exp_lane(p, 2*bt+1), exp_lane(p, 2*bt)};
                automatic bit lastb = (bt == nb - 1);
                automatic string tag;
                if (bt == 0) tag = "R1 R2 header beat 0";
                else if (bt == 1 && cfg_h4(p)) tag = "R3 header beat 1";
                else if (!cfg_h4(p) && bt == 1) tag = "R7 three-dword second beat";
                else if (cfg_a2(p)) tag = "R4 R6 unaligned payload beat";
                else tag = "R4 R5 aligned payload beat";
                chk(out_data == e, tag, out_data, e);
                if (bt == 0) begin
                    chk(out_data[31:24] == hbyte(p, 0) && out_data[7:0] == hbyte(p, 3),
                        "R2 header byte order", {56'h0, out_data[31:24]}, {56'h0, hbyte(p, 0)});
                end
                chk(out_sop == (bt == 0), "R1 sop position", {63'h0, out_sop}, {63'h0, bt == 0});
                chk(out_eop == lastb, "R8 eop position", {63'h0, out_eop}, {63'h0, lastb});
                chk(out_hi_empty == (lastb && (t % 2 == 1)), "R9 upper lane empty flag",
                    {63'h0, out_hi_empty}, {63'h0, lastb && (t % 2 == 1)});
                if (lastb) begin
                    pk_mon++;
                    bt = 0;
                end else begin
                    bt++;
                end
            end
        end
    end

    task automatic send_pkt(input int p);
        if (p == 0 || p == NCFG) begin
            pay_valid = 1'b1;
            pay_data  = 32'hDEAD_BEEF;
            repeat (2) begin
                @(negedge clk); #1;
                chk(pay_ready == 1'b0, "R12 payload refused while idle", {63'h0, pay_ready}, 64'h0);
            end
            pay_valid = 1'b0;
        end
        @(negedge clk); #1;
        while (!hdr_ready) begin
            @(negedge clk); #1;
        end
        hdr_load  = 1'b1;
        hdr_four  = cfg_h4(p);
        addr_bit2 = cfg_a2(p);
        pay_len   = LEN_W'(cfg_n(p));
        for (int j = 0; j < 16; j++) hdr_bytes[8*j +: 8] = hbyte(p, j);
        @(negedge clk); #1;
        if (p % 4 == 2) begin
            hdr_bytes = {4{32'hBAD0_0BAD}};
            hdr_four  = ~hdr_four;
            pay_len   = LEN_W'(9);
            chk(hdr_ready == 1'b0, "R11 header load blocked mid-packet", {63'h0, hdr_ready}, 64'h0);
            @(negedge clk); #1;
        end
        hdr_load = 1'b0;
        for (int i = 0; i < cfg_n(p); i++) begin
            pay_valid = 1'b1;
            pay_data  = pword(p, i);
            while (!pay_ready) begin
                @(negedge clk); #1;
            end
            @(posedge clk);
            @(negedge clk); #1;
            pay_valid = 1'b0;
            if (p % 5 == 3) begin
                @(negedge clk); #1;
            end
        end
        pay_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0 && hdr_ready == 1'b1 && pay_ready == 1'b0, "R11 R12 reset state",
            {61'h0, out_valid, hdr_ready, pay_ready}, 64'h2);
        mon_on = 1'b1;
        for (int p = 0; p < NPK; p++) send_pkt(p);
        while (pk_mon < NPK) @(negedge clk);
        @(negedge clk); #1;
        chk(hdr_ready == 1'b1 && out_valid == 1'b0, "R11 ready after final eop",
            {62'h0, hdr_ready, out_valid}, 64'h2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired at packet %0d actual=%0d expected=%0d", pk_mon, pk_mon, NPK);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule